// File: doc/BRIEF.md
# Radio Data Block Syndrome Checker

This block receives the serial data stream of a radio data channel one bit at a time, on single-cycle bit strobes, and keeps the last 26 received bits in a block register. Each time a block is checked, a sequential divider reduces the 26-bit word modulo the shortened cyclic code generator x^10+x^8+x^7+x^5+x^4+x^3+1, one bit per system clock. The resulting 10-bit syndrome is compared with the six offset-word syndromes. A match raises a sticky valid-syndrome flag and reports which offset word was found.

A check starts in one of two ways. In normal operation, every accepted bit launches a check automatically, which gives a sliding search for block alignment. For software error correction, the error-correction mode input freezes the block register. A start strobe then launches a check of the frozen word, and a busy flag covers the 26-cycle calculation. While the block register is frozen, a shadow register keeps capturing the live stream. A restore strobe copies the shadow back into the block register once correction has finished.

Top module: `syn_checker`

## Requirements
- R1: On a bit strobe with `ecm` low and `restore` low, the block register shifts left by one and takes `bit_data` into bit 0. The first bit received ends up in bit 25 after 26 strobes.
- R2: The shadow register shifts in `bit_data` the same way on every bit strobe, whatever the state of `ecm`.
- R3: While `ecm` is high, bit strobes leave the block register unchanged.
- R4: A `restore` pulse loads the block register with the shadow register's value on the next clock edge.
- R5: A `cal_start` pulse, or an automatic launch, taken while idle makes `busy` high from the next cycle for exactly 26 cycles. `syndrome`, `vsi` and `blk_code` update in the cycle in which `busy` falls.
- R6: A bit strobe taken with `ecm` low launches a check automatically one clock after the block register has captured the bit. A strobe with `ecm` high launches nothing.
- R7: `syndrome` is the remainder of the block polynomial modulo 0x5B9 (generator bits x^10..x^0). Bit 25 of the block register is the highest-degree coefficient.
- R8: When the syndrome equals an offset word, `vsi` is set and `blk_code` gives the match. The encoding is A=0x0FC→0, B=0x198→1, C=0x168→2, C'=0x350→3, D=0x1B4→4, E=0x000→5.
- R9: When a check ends with any other syndrome, `vsi` is cleared and `blk_code` reads 7.
- R10: `vsi` holds its value between checks until `vsi_clr` is pulsed. A check completing on the same edge as `vsi_clr` takes priority over the clear.
- R11: `irq` is high exactly when `vsi` and the enable `vse` are both high.
- R12: A start request, whether from `cal_start` or an automatic launch, made while `busy` is high is ignored. It neither restarts nor extends the running check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_strobe | input | 1 | One-cycle pulse: `bit_data` holds a new channel bit |
| bit_data | input | 1 | Serial channel data bit |
| ecm | input | 1 | Error-correction mode: freezes the block register |
| cal_start | input | 1 | One-cycle start request for a check of the block register |
| restore | input | 1 | One-cycle pulse: copy the shadow register into the block register |
| vsi_clr | input | 1 | One-cycle pulse: clear the valid-syndrome flag |
| vse | input | 1 | Interrupt enable for the valid-syndrome flag |
| busy | output | 1 | A syndrome calculation is running |
| vsi | output | 1 | Sticky valid-syndrome flag |
| irq | output | 1 | Interrupt request |
| blk_code | output | 3 | Offset word found by the last check (7 = none) |
| syndrome | output | 10 | Syndrome of the last check |
| blk_reg | output | 26 | Block register contents |
| shadow_reg | output | 26 | Shadow register contents |

## Verification
Six codewords are built in the bench by independent long division, one for each offset word and each with different data. Loading them shows that every offset maps to its own code and that the bit order into the block register is right. A codeword with one bit flipped shows the invalid path, including the clearing of `vsi`. Strobes taken in error-correction mode separate the frozen block register from the moving shadow. A start pulse issued halfway through a calculation shows that a running check cannot be restarted. A clear pulse placed on the completion edge shows that a new result wins over the clear.

// File: rtl/syn_pkg.sv
// Package: shared constants and types for the radio data syndrome checker.
// Assumes a 10-bit syndrome; the offset words are defined for that width.
package syn_pkg;
    localparam int SYN_W_FIX = 10;
    localparam int N_OFFSETS = 6;
    localparam logic [SYN_W_FIX-1:0] GEN_LOW = 10'h1B9; // generator without x^10

    typedef enum logic [2:0] {
        CODE_A    = 3'd0,
        CODE_B    = 3'd1,
        CODE_C    = 3'd2,
        CODE_CP   = 3'd3,
        CODE_D    = 3'd4,
        CODE_E    = 3'd5,
        CODE_NONE = 3'd7
    } blk_code_t;

    // Offset-word syndrome for each code index (index equals code value).
    function automatic logic [SYN_W_FIX-1:0] offset_word(input int idx);
        case (idx)
            0:       return 10'h0FC;
            1:       return 10'h198;
            2:       return 10'h168;
            3:       return 10'h350;
            4:       return 10'h1B4;
            default: return 10'h000;
        endcase
    endfunction
endpackage

// File: rtl/syn_shift.sv
// Module: block register and shadow register.
// The block register shifts on strobes unless frozen; the shadow always shifts.
// Assumes bit_strobe is a single-cycle pulse; restore has priority over shifting.
module syn_shift #(
    parameter int BLK_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_strobe,
    input  logic             bit_data,
    input  logic             freeze,
    input  logic             restore,
    output logic [BLK_W-1:0] blk_q,
    output logic [BLK_W-1:0] shadow_q
);
    // Block register: restore, else shift when not frozen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q <= '0;
        end else if (restore) begin
            blk_q <= shadow_q;
        end else if (bit_strobe && !freeze) begin
            blk_q <= {blk_q[BLK_W-2:0], bit_data};
        end
    end

    // Shadow register: follows the live stream at all times.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (bit_strobe) begin
            shadow_q <= {shadow_q[BLK_W-2:0], bit_data};
        end
    end
endmodule

// File: rtl/syn_engine.sv
// Module: bit-serial polynomial divider producing the block syndrome.
// Captures the block on an accepted go, then divides one bit per clock,
// most significant bit first; go is ignored while busy.
module syn_engine #(
    parameter int               BLK_W = 26,
    parameter int               SYN_W = 10,
    parameter logic [SYN_W-1:0] POLY  = 10'h1B9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [BLK_W-1:0] blk_in,
    output logic             busy,
    output logic             done,
    output logic [SYN_W-1:0] rem_next,
    output logic [SYN_W-1:0] syn_q
);
    localparam int CNT_W = $clog2(BLK_W + 1);

    logic [BLK_W-1:0] work;
    logic [SYN_W-1:0] rem;
    logic [CNT_W-1:0] cnt;

    // One division step: shift in the next bit, reduce when x^SYN_W appears.
    always_comb begin
        rem_next = {rem[SYN_W-2:0], work[BLK_W-1]};
        if (rem[SYN_W-1]) begin
            rem_next = rem_next ^ POLY;
        end
    end

    // Completion marker: the last division step happens on this edge.
    assign done = busy && (cnt == CNT_W'(1));

    // Calculation sequencer: load, step, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt   <= '0;
            work  <= '0;
            rem   <= '0;
            syn_q <= '0;
        end else if (go && !busy) begin
            busy <= 1'b1;
            cnt  <= CNT_W'(BLK_W);
            work <= blk_in;
            rem  <= '0;
        end else if (busy) begin
            work <= {work[BLK_W-2:0], 1'b0};
            rem  <= rem_next;
            cnt  <= cnt - CNT_W'(1);
            if (done) begin
                busy  <= 1'b0;
                syn_q <= rem_next;
            end
        end
    end
endmodule

// File: rtl/syn_match.sv
// Module: compares a syndrome with the six offset words.
// Purely combinational; the offset words are distinct, so at most one hit.
module syn_match
    import syn_pkg::*;
#(
    parameter int SYN_W = 10
) (
    input  logic [SYN_W-1:0] syn,
    output logic             hit_any,
    output logic [2:0]       code
);
    logic [N_OFFSETS-1:0] hit;

    // One comparator per offset word.
    for (genvar i = 0; i < N_OFFSETS; i++) begin : g_cmp
        assign hit[i] = (syn == SYN_W'(offset_word(i)));
    end

    assign hit_any = |hit;

    // Encode the matching index, or the no-match code.
    always_comb begin
        code = CODE_NONE;
        for (int i = N_OFFSETS - 1; i >= 0; i--) begin
            if (hit[i]) code = 3'(i);
        end
    end
endmodule

// File: rtl/syn_checker.sv
// Module: top of the syndrome checker.
// Launches a check automatically after each accepted bit (ecm low) or on
// cal_start, keeps a sticky valid-syndrome flag and gates the interrupt.
module syn_checker
    import syn_pkg::*;
#(
    parameter int BLK_W = 26,
    parameter int SYN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_strobe,
    input  logic             bit_data,
    input  logic             ecm,
    input  logic             cal_start,
    input  logic             restore,
    input  logic             vsi_clr,
    input  logic             vse,
    output logic             busy,
    output logic             vsi,
    output logic             irq,
    output logic [2:0]       blk_code,
    output logic [SYN_W-1:0] syndrome,
    output logic [BLK_W-1:0] blk_reg,
    output logic [BLK_W-1:0] shadow_reg
);
    logic             auto_go;
    logic             launch;
    logic             done;
    logic [SYN_W-1:0] rem_next;
    logic             hit_any;
    logic [2:0]       code_next;

    syn_shift #(.BLK_W(BLK_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_strobe (bit_strobe),
        .bit_data   (bit_data),
        .freeze     (ecm),
        .restore    (restore),
        .blk_q      (blk_reg),
        .shadow_q   (shadow_reg)
    );

    // Automatic launch one cycle after a bit enters the block register.
    always_ff @(posedge clk) begin
        if (!rst_n) auto_go <= 1'b0;
        else        auto_go <= bit_strobe && !ecm;
    end

    assign launch = auto_go || cal_start;

    syn_engine #(.BLK_W(BLK_W), .SYN_W(SYN_W), .POLY(SYN_W'(GEN_LOW))) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (launch),
        .blk_in   (blk_reg),
        .busy     (busy),
        .done     (done),
        .rem_next (rem_next),
        .syn_q    (syndrome)
    );

    syn_match #(.SYN_W(SYN_W)) u_match (
        .syn     (rem_next),
        .hit_any (hit_any),
        .code    (code_next)
    );

    // Sticky flag: a completing check wins over a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       vsi <= 1'b0;
        else if (done)    vsi <= hit_any;
        else if (vsi_clr) vsi <= 1'b0;
    end

    // Block code of the latest completed check.
    always_ff @(posedge clk) begin
        if (!rst_n)    blk_code <= CODE_NONE;
        else if (done) blk_code <= code_next;
    end

    assign irq = vsi && vse;
endmodule

// File: rtl/syn_checker_sva.sv
// Module: assertion checker for syn_checker, attached with bind.
// Observes ports and the internal launch request only.
module syn_checker_sva #(
    parameter int BLK_W = 26
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_strobe,
    input logic             bit_data,
    input logic             ecm,
    input logic             restore,
    input logic             vsi_clr,
    input logic             launch,
    input logic             busy,
    input logic             vsi,
    input logic             irq,
    input logic [2:0]       blk_code,
    input logic [BLK_W-1:0] blk_reg,
    input logic [BLK_W-1:0] shadow_reg
);
    localparam int RUN_W = $clog2(BLK_W + 2) + 1;
    logic [RUN_W-1:0] run;

    // Length of the current busy period.
    always_ff @(posedge clk) begin
        if (!rst_n)    run <= '0;
        else if (busy) run <= run + RUN_W'(1);
        else           run <= '0;
    end

    assert_block_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_strobe && !ecm && !restore) |=>
            blk_reg == {$past(blk_reg[BLK_W-2:0]), $past(bit_data)});

    assert_shadow_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe |=> shadow_reg == {$past(shadow_reg[BLK_W-2:0]), $past(bit_data)});

    assert_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ecm && !restore) |=> $stable(blk_reg));

    assert_restore_R4: assert property (@(posedge clk) disable iff (!rst_n)
        restore |=> blk_reg == $past(shadow_reg));

    assert_launch_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && !busy) |=> busy);

    assert_busy_length_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run == RUN_W'(BLK_W));

    assert_code_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vsi |-> blk_code <= 3'd5);

    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (vsi && !vsi_clr && !busy) |=> vsi);

    assert_irq_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> vsi);
endmodule

bind syn_checker syn_checker_sva #(.BLK_W(BLK_W)) u_sva (.*);

// File: tb/tb_syn_checker.sv
`timescale 1ns/1ps
// Directed bench for syn_checker: one task per scenario.
module tb_syn_checker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_strobe = 1'b0, bit_data = 1'b0, ecm = 1'b0;
    logic        cal_start = 1'b0, restore = 1'b0, vsi_clr = 1'b0, vse = 1'b0;
    logic        busy, vsi, irq;
    logic [2:0]  blk_code;
    logic [9:0]  syndrome;
    logic [25:0] blk_reg, shadow_reg;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    syn_checker dut (
        .clk(clk), .rst_n(rst_n), .bit_strobe(bit_strobe), .bit_data(bit_data),
        .ecm(ecm), .cal_start(cal_start), .restore(restore), .vsi_clr(vsi_clr),
        .vse(vse), .busy(busy), .vsi(vsi), .irq(irq), .blk_code(blk_code),
        .syndrome(syndrome), .blk_reg(blk_reg), .shadow_reg(shadow_reg)
    );

    // Record one comparison.
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Long-division remainder modulo 0x5B9.
    function automatic logic [9:0] ref_rem(input logic [25:0] w);
        logic [25:0] r = w;
        for (int i = 25; i >= 10; i--) begin
            if (r[i]) r = r ^ (26'h5B9 << (i - 10));
        end
        return r[9:0];
    endfunction

    // Codeword with the given data whose syndrome equals the offset.
    function automatic logic [25:0] make_word(input logic [15:0] d, input logic [9:0] off);
        return {d, ref_rem({d, 10'b0}) ^ off};
    endfunction

    // One strobed bit followed by a gap long enough for a full check.
    task automatic send_bit(input logic b);
        @(negedge clk); bit_data = b; bit_strobe = 1'b1;
        @(negedge clk); bit_strobe = 1'b0;
        repeat (30) @(negedge clk);
    endtask

    task automatic load_word(input logic [25:0] w);
        for (int i = 25; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic t_reset();
        chk("R5 reset busy", busy, 0);
        chk("R10 reset vsi", vsi, 0);
        chk("R11 reset irq", irq, 0);
        chk("R9 reset code", blk_code, 7);
        chk("R1 reset block", blk_reg, 0);
        chk("R2 reset shadow", shadow_reg, 0);
    endtask

    // Each offset word in turn, with distinct data.
    task automatic t_valid_words();
        logic [9:0] offs [6] = '{10'h0FC, 10'h198, 10'h168, 10'h350, 10'h1B4, 10'h000};
        for (int k = 0; k < 6; k++) begin
            logic [25:0] w = make_word(16'hA35C ^ (16'h1357 * k), offs[k]);
            load_word(w);
            chk("R1 block contents", blk_reg, w);
            chk("R2 shadow contents", shadow_reg, w);
            chk("R7 syndrome", syndrome, ref_rem(w));
            chk("R8 vsi set", vsi, 1);
            chk("R8 block code", blk_code, k);
        end
    endtask

    task automatic t_invalid();
        logic [25:0] w = make_word(16'h4C21, 10'h168) ^ 26'h0000400;
        load_word(w);
        chk("R7 syndrome corrupted", syndrome, ref_rem(w));
        chk("R9 vsi cleared", vsi, 0);
        chk("R9 code none", blk_code, 7);
    endtask

    // Automatic launch timing, and no launch in correction mode.
    task automatic t_auto_launch();
        logic [25:0] b0, s0;
        @(negedge clk); bit_data = 1'b1; bit_strobe = 1'b1;
        @(negedge clk); bit_strobe = 1'b0;
        chk("R6 not yet busy", busy, 0);
        @(negedge clk);
        chk("R6 auto busy", busy, 1);
        repeat (30) @(negedge clk);
        ecm = 1'b1;
        b0 = blk_reg; s0 = shadow_reg;
        @(negedge clk); bit_data = 1'b0; bit_strobe = 1'b1;
        @(negedge clk); bit_strobe = 1'b0;
        @(negedge clk);
        chk("R6 no launch in ecm", busy, 0);
        chk("R3 block frozen", blk_reg, b0);
        chk("R2 shadow moves in ecm", shadow_reg, {s0[24:0], 1'b0});
    endtask

    // Software check while frozen, with a start pulse mid-calculation.
    task automatic t_soft_check();
        logic [25:0] w = make_word(16'h0F0F, 10'h1B4);
        int n;
        ecm = 1'b0;
        load_word(w);
        ecm = 1'b1;
        for (int i = 0; i < 5; i++) send_bit(i[0]);
        chk("R3 block frozen over strobes", blk_reg, w);
        chk("R2 shadow after strobes", shadow_reg, {w[20:0], 5'b01010});
        @(negedge clk); vsi_clr = 1'b1;
        @(negedge clk); vsi_clr = 1'b0;
        chk("R10 cleared", vsi, 0);
        cal_start = 1'b1;
        @(negedge clk); cal_start = 1'b0;
        chk("R5 busy after start", busy, 1);
        n = 0;
        while (busy === 1'b1 && n < 100) begin
            n++;
            cal_start = (n == 10);
            @(negedge clk);
        end
        cal_start = 1'b0;
        chk("R12 busy length with extra start", n, 26);
        chk("R5 vsi ready at end", vsi, 1);
        chk("R5 code ready at end", blk_code, 4);
    endtask

    // Sticky flag, interrupt gating and clear-versus-set priority.
    task automatic t_sticky_irq();
        vse = 1'b0;
        @(negedge clk);
        chk("R11 irq masked", irq, 0);
        vse = 1'b1;
        @(negedge clk);
        chk("R11 irq enabled", irq, 1);
        repeat (40) @(negedge clk);
        chk("R10 vsi held", vsi, 1);
        vsi_clr = 1'b1;
        @(negedge clk); vsi_clr = 1'b0;
        chk("R10 vsi cleared", vsi, 0);
        chk("R11 irq follows clear", irq, 0);
        cal_start = 1'b1;
        @(negedge clk); cal_start = 1'b0;
        repeat (24) @(negedge clk);
        chk("R10 still clear before end", vsi, 0);
        @(negedge clk); vsi_clr = 1'b1;
        @(negedge clk); vsi_clr = 1'b0;
        chk("R10 set wins over clear", vsi, 1);
        chk("R5 idle after end", busy, 0);
    endtask

    task automatic t_restore();
        logic [25:0] s0 = shadow_reg;
        @(negedge clk); restore = 1'b1;
        @(negedge clk); restore = 1'b0;
        chk("R4 restore copies shadow", blk_reg, s0);
        ecm = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_valid_words();
        t_invalid();
        t_auto_launch();
        t_soft_check();
        t_sticky_irq();
        t_restore();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule